// File: doc/BRIEF.md
# SPI Control Register Slave

This block is the device-side serial port of a mixed-signal control chip. A host talks to it in fixed 24-bit frames using SPI mode 0 (clock idles low, data sampled on the rising edge, MISO updated on the falling edge). Each frame carries a read/write flag, a six-bit register address and a sixteen-bit data word. On a write the word lands in the addressed register when chip select is released. On a read the slave returns the addressed register within the same frame. The register contents are also driven out in parallel to the analog and converter logic of the chip.

The slave counts the clock edges in each frame. It flags frames that are too short or too long. It also flags addresses outside the implemented map and, when enabled, frames whose parity is wrong. Such frames never change a register. These alarms are sticky, can be masked per alarm, and clear when the host reads them. A soft-reset bit in the control register returns every writable register to zero. The bit itself always reads back as zero.

The serial pins are brought into the system clock domain through synchronizers. The serial clock must therefore run well below the system clock.

Top module: `ctl_spi_regfile`

## Requirements
- R1: A frame is 24 bits, MSB first, sampled on rising SCLK while CSN is low. Bit 23 = 1 means read and 0 means write. Bits 22:17 are the address, bits 16:1 are the data and bit 0 is the parity/spare bit. A valid write takes effect after CSN rises.
- R2: During a read frame, MISO carries the addressed register in frame positions 16:1 and is low in positions 23:17 and 0. MISO is low outside a frame.
- R3: Address 0x00 holds the parity enable at bit 15 and the soft-reset request at bit 14, which reads 0. It also holds a fixed identifier 0x0A in bits 11:4 and a revision (parameter, default 0x1) in bits 3:0. Writes to the identifier and the revision are ignored.
- R4: Writing 0x00 with bit 14 set clears every writable register, including the parity enable and the alarm masks, and clears all alarms. The soft-reset bit then reads 0.
- R5: Register fields are as follows. At 0x02, alarm masks in bits 15:12. At 0x03, nine enables in bits 8:0. At 0x04, the linearizer setting in bits 7:0. At 0x05, the sideband select at bit 10, the Q phase at bits 7:4 and the I phase at bits 3:0. At 0x06, the converter control in bits 3:0. At 0x0C, the converter status input at bit 8 and its result in bits 7:0. All other bits read 0.
- R6: A frame with fewer than 24 rising edges sets alarm bit 14 of 0x01 and commits nothing.
- R7: A frame with more than 24 rising edges sets alarm bit 13 and commits nothing.
- R8: A 24-edge frame addressing anything other than 0x00–0x06 or 0x0C sets alarm bit 12 and commits nothing. A read of such an address returns 0.
- R9: When parity is enabled, a 24-edge frame with an odd number of ones sets alarm bit 15 and is not committed. When parity is disabled, parity is not checked.
- R10: Alarms are sticky. A read of 0x01 returns them and clears them. A set bit in mask register 0x02 (same bit position) prevents the matching alarm from setting.
- R11: Writes to the read-only addresses 0x01 and 0x0C change nothing.
- R12: The parallel outputs follow the stored registers and change only when a frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-slave data |
| spi_miso | output | 1 | Slave-to-host data |
| adc_status_i | input | 1 | Converter result-valid flag, shown at 0x0C bit 8 |
| adc_value_i | input | 8 | Converter result, shown at 0x0C bits 7:0 |
| parity_en_o | output | 1 | Parity checking enabled |
| enable_o | output | 9 | Block enables |
| linearize_o | output | 8 | Linearizer setting |
| lo_sideband_o | output | 1 | Sideband select |
| i_phase_o | output | 4 | I-path phase trim |
| q_phase_o | output | 4 | Q-path phase trim |
| adc_ctrl_o | output | 4 | Converter control bits |
| alarm_mask_o | output | 4 | Alarm masks (parity, short, long, address) |
| alarm_o | output | 4 | Sticky alarms (parity, short, long, address) |

## Verification
The bench targets the edge-count boundary from both sides, with a 20-edge and a 26-edge write. A design with an off-by-one count would either commit a truncated word or miss the alarm. It checks that the header is decoded exactly after the seventh edge. A design that loads the reply one edge late would return a word shifted by one bit. It checks parity with the check both enabled and disabled. It checks that a masked alarm stays low and that reading the alarm register clears it, so a non-sticky or never-clearing alarm shows up. The bench also confirms that soft reset clears the parity enable and the masks along with the other registers, and that read-only fields keep their fixed values after writes of all ones.

// File: rtl/spi_rf_pkg.sv
// Package: shared frame layout, address map and field widths for the
// SPI control register slave. Assumes a single fixed frame format.
package spi_rf_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 16;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int ALM_W      = 4;
    localparam int EN_W       = 9;
    localparam int LIN_W      = 8;
    localparam int PH_W       = 4;
    localparam int ADCC_W     = 4;
    localparam int ADCV_W     = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] A_ALARM  = 6'h01;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'h02;
    localparam logic [ADDR_W-1:0] A_EN     = 6'h03;
    localparam logic [ADDR_W-1:0] A_LIN    = 6'h04;
    localparam logic [ADDR_W-1:0] A_LO     = 6'h05;
    localparam logic [ADDR_W-1:0] A_ADC    = 6'h06;
    localparam logic [ADDR_W-1:0] A_ADCOUT = 6'h0C;

    // Frame content captured when chip select is released.
    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              odd_ones;
        logic              too_few;
        logic              too_many;
    } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous pins.
// Assumes each bit may be sampled on its own; no bus coherence is implied.
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the pin values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
// Mode-0 frame shifter: counts rising SCLK edges, shifts MOSI in, asks for
// read data once the header is complete and shifts it out on falling edges.
// Assumes synchronized pin levels and an SCLK well below clk.
module spi_frame_engine
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              frame_done,
    output frame_t            frame,
    output logic              miso
);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    logic                  sclk_d, csn_d;
    logic                  sclk_rise, sclk_fall, csn_rise, csn_fall;
    logic [FRAME_BITS-1:0] rx;
    logic [CNT_W-1:0]      cnt;
    logic [DATA_W-1:0]     tx;
    logic                  tx_act;

    // Remember previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign csn_rise  = csn_s & ~csn_d;
    assign csn_fall  = ~csn_s & csn_d;

    assign rd_addr = rx[ADDR_W-1:0];
    assign rd_req  = ~csn_s & sclk_fall & (cnt == CNT_HDR) & rx[HDR_BITS-1];

    // Receive shift, edge count and transmit shift for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx     <= '0;
            cnt    <= '0;
            tx     <= '0;
            tx_act <= 1'b0;
        end else if (csn_fall) begin
            rx     <= '0;
            cnt    <= '0;
            tx_act <= 1'b0;
        end else if (csn_rise) begin
            tx_act <= 1'b0;
        end else if (!csn_s) begin
            if (sclk_rise) begin
                rx <= {rx[FRAME_BITS-2:0], mosi_s};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
            if (rd_req) begin
                tx     <= rd_data;
                tx_act <= 1'b1;
            end else if (sclk_fall && tx_act) begin
                tx <= {tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign miso       = tx_act & tx[DATA_W-1];
    assign frame_done = csn_rise;

    // Decode the captured frame for the register bank.
    always_comb begin
        frame.is_read  = rx[FRAME_BITS-1];
        frame.addr     = rx[FRAME_BITS-2 -: ADDR_W];
        frame.data     = rx[DATA_W:1];
        frame.odd_ones = ^rx;
        frame.too_few  = cnt < CNT_FULL;
        frame.too_many = cnt > CNT_FULL;
    end
endmodule

// File: rtl/ctl_reg_bank.sv
// Register bank: holds the writable fields, commits validated write frames,
// raises masked sticky alarms and returns read data by address.
// Assumes frame_done and rd_req never coincide (they come from one frame).
module ctl_reg_bank
    import spi_rf_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h0A,
    parameter logic [3:0] REV     = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  frame_t            frame,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              adc_status,
    input  logic [ADCV_W-1:0] adc_value,
    output logic              par_en,
    output logic [EN_W-1:0]   en,
    output logic [LIN_W-1:0]  lin,
    output logic              lo_sb,
    output logic [PH_W-1:0]   i_ph,
    output logic [PH_W-1:0]   q_ph,
    output logic [ADCC_W-1:0] adc_ctl,
    output logic [ALM_W-1:0]  mask,
    output logic [ALM_W-1:0]  alarm
);
    logic              len_ok, par_bad, addr_bad, commit, soft_rst;
    logic [ALM_W-1:0]  new_alarm;
    logic [DATA_W-1:0] wd;

    function automatic logic addr_impl(input logic [ADDR_W-1:0] a);
        return (a <= A_ADC) || (a == A_ADCOUT);
    endfunction

    assign wd        = frame.data;
    assign len_ok    = ~frame.too_few & ~frame.too_many;
    assign par_bad   = len_ok & par_en & frame.odd_ones;
    assign addr_bad  = len_ok & ~addr_impl(frame.addr);
    assign commit    = frame_done & len_ok & ~par_bad & ~addr_bad & ~frame.is_read;
    assign soft_rst  = commit & (frame.addr == A_CTRL) & wd[14];
    assign new_alarm = frame_done ?
        ({par_bad, frame.too_few, frame.too_many, addr_bad} & ~mask) : '0;

    // Commit validated writes; reset or soft reset clears every field.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            par_en  <= 1'b0;
            mask    <= '0;
            en      <= '0;
            lin     <= '0;
            lo_sb   <= 1'b0;
            i_ph    <= '0;
            q_ph    <= '0;
            adc_ctl <= '0;
        end else if (commit) begin
            case (frame.addr)
                A_CTRL: par_en  <= wd[15];
                A_MASK: mask    <= wd[15:12];
                A_EN:   en      <= wd[EN_W-1:0];
                A_LIN:  lin     <= wd[LIN_W-1:0];
                A_LO: begin
                    lo_sb <= wd[10];
                    q_ph  <= wd[7:4];
                    i_ph  <= wd[3:0];
                end
                A_ADC:  adc_ctl <= wd[ADCC_W-1:0];
                default: ;
            endcase
        end
    end

    // Sticky alarms: set at frame end, cleared when the alarm register is read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            alarm <= '0;
        else
            alarm <= ((rd_req && rd_addr == A_ALARM) ? '0 : alarm) | new_alarm;
    end

    // Assemble read data for the addressed register.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data = {par_en, 3'b000, CHIP_ID, REV};
            A_ALARM:  rd_data = {alarm, 12'h000};
            A_MASK:   rd_data = {mask, 12'h000};
            A_EN:     rd_data[EN_W-1:0] = en;
            A_LIN:    rd_data[LIN_W-1:0] = lin;
            A_LO:     rd_data = {5'b00000, lo_sb, 2'b00, q_ph, i_ph};
            A_ADC:    rd_data[ADCC_W-1:0] = adc_ctl;
            A_ADCOUT: rd_data[ADCV_W:0] = {adc_status, adc_value};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ctl_spi_regfile.sv
// Top: SPI mode-0 control register slave with parallel register outputs.
// Assumes SCLK half period of at least four clk cycles.
module ctl_spi_regfile
    import spi_rf_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CHIP_ID     = 8'h0A,
    parameter logic [3:0] REV         = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              adc_status_i,
    input  logic [ADCV_W-1:0] adc_value_i,
    output logic              parity_en_o,
    output logic [EN_W-1:0]   enable_o,
    output logic [LIN_W-1:0]  linearize_o,
    output logic              lo_sideband_o,
    output logic [PH_W-1:0]   i_phase_o,
    output logic [PH_W-1:0]   q_phase_o,
    output logic [ADCC_W-1:0] adc_ctrl_o,
    output logic [ALM_W-1:0]  alarm_mask_o,
    output logic [ALM_W-1:0]  alarm_o
);
    logic [2:0]        pins_s;
    logic              rd_req, frame_done;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    frame_t            frame;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sclk, spi_csn, spi_mosi}), .q(pins_s)
    );

    spi_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[2]), .csn_s(pins_s[1]), .mosi_s(pins_s[0]),
        .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .frame_done(frame_done), .frame(frame), .miso(spi_miso)
    );

    ctl_reg_bank #(.CHIP_ID(CHIP_ID), .REV(REV)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .frame_done(frame_done), .frame(frame),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .adc_status(adc_status_i), .adc_value(adc_value_i),
        .par_en(parity_en_o), .en(enable_o), .lin(linearize_o),
        .lo_sb(lo_sideband_o), .i_ph(i_phase_o), .q_ph(q_phase_o),
        .adc_ctl(adc_ctrl_o), .mask(alarm_mask_o), .alarm(alarm_o)
    );
endmodule

// File: rtl/ctl_spi_regfile_chk.sv
// Checker: temporal properties of the register slave, bound to the top.
module ctl_spi_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_done,
    input logic       spi_miso,
    input logic [8:0] enable_o,
    input logic [7:0] linearize_o,
    input logic [3:0] alarm_mask_o,
    input logic [3:0] alarm_o
);
    // R12
    cfg_change_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(enable_o) || !$stable(linearize_o)) |-> $past(frame_done));

    // R10
    masked_alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alarm_o & ~$past(alarm_o) & $past(alarm_mask_o)) == 4'b0000));

    // R6
    alarm_set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alarm_o & ~$past(alarm_o)) != 4'b0000) |-> $past(frame_done));

    // R2
    miso_idle_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !spi_miso);
endmodule

bind ctl_spi_regfile ctl_spi_regfile_chk u_chk (.*);

// File: tb/tb_ctl_spi_regfile.sv
module tb_ctl_spi_regfile;
    localparam int HALF = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       adc_status_i = 1'b0;
    logic [7:0] adc_value_i = 8'h00;
    logic       parity_en_o, lo_sideband_o;
    logic [8:0] enable_o;
    logic [7:0] linearize_o;
    logic [3:0] i_phase_o, q_phase_o, adc_ctrl_o, alarm_mask_o, alarm_o;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;

    ctl_spi_regfile dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input logic rd, input logic [5:0] a, input logic [15:0] d);
        logic [23:0] f;
        f    = {rd, a, d, 1'b0};
        f[0] = ^f[23:1];
        return f;
    endfunction

    task automatic xfer(input logic [23:0] f, input int nedge, output logic [23:0] got);
        got = '0;
        @(negedge clk) spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nedge; i++) begin
            spi_mosi = (i < 24) ? f[23-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 24) got[23-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_csn  = 1'b1;
        spi_mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        logic [23:0] g;
        xfer(mk(1'b0, a, d), 24, g);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        logic [23:0] g;
        xfer(mk(1'b1, a, 16'h0), 24, g);
        d = g[16:1];
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R12 reset outputs", {parity_en_o, enable_o, linearize_o, lo_sideband_o,
             i_phase_o, q_phase_o, adc_ctrl_o, alarm_mask_o, alarm_o}, 32'h0);
        rd(6'h00, d); chk("R3 ctrl id/rev", d, 16'h00A1);
        rd(6'h01, d); chk("R10 no alarm after reset", d, 16'h0000);
    endtask

    task automatic t_rw();
        logic [23:0] g;
        logic [15:0] d;
        wr(6'h03, 16'h01FF);
        xfer(mk(1'b1, 6'h03, 16'h0), 24, g);
        chk("R2 read frame positions", g, {7'h00, 16'h01FF, 1'b0});
        chk("R1 enable_o after write", enable_o, 9'h1FF);
        wr(6'h03, 16'hFFFF); rd(6'h03, d); chk("R5 enable width", d, 16'h01FF);
        wr(6'h04, 16'hFFA5); rd(6'h04, d); chk("R5 linearizer", d, 16'h00A5);
        chk("R12 linearize_o", linearize_o, 8'hA5);
        wr(6'h05, 16'hFFFF); rd(6'h05, d); chk("R5 lo path", d, 16'h04FF);
        wr(6'h05, 16'h0436);
        chk("R12 lo outputs", {lo_sideband_o, q_phase_o, i_phase_o}, 9'h136);
        wr(6'h06, 16'hFFFF); rd(6'h06, d); chk("R5 adc control", d, 16'h000F);
        wr(6'h02, 16'hFFFF); rd(6'h02, d); chk("R5 mask field", d, 16'hF000);
        wr(6'h02, 16'h0000);
    endtask

    task automatic t_ro();
        logic [15:0] d;
        adc_status_i = 1'b1; adc_value_i = 8'h3C;
        wr(6'h0C, 16'hFFFF); rd(6'h0C, d); chk("R11 adc out read-only", d, 16'h013C);
        wr(6'h01, 16'hFFFF); rd(6'h01, d); chk("R11 alarm read-only", d, 16'h0000);
        wr(6'h00, 16'hBFFF); rd(6'h00, d); chk("R3 ctrl ro fields", d, 16'h80A1);
        chk("R12 parity_en_o", parity_en_o, 1'b1);
        wr(6'h00, 16'h0000);
    endtask

    task automatic t_len();
        logic [23:0] g;
        logic [15:0] d;
        xfer(mk(1'b0, 6'h03, 16'h0055), 20, g);
        chk("R6 short frame not committed", enable_o, 9'h1FF);
        rd(6'h01, d); chk("R6 short alarm", d, 16'h4000);
        rd(6'h01, d); chk("R10 alarm cleared on read", d, 16'h0000);
        xfer(mk(1'b0, 6'h03, 16'h0055), 26, g);
        chk("R7 long frame not committed", enable_o, 9'h1FF);
        rd(6'h01, d); chk("R7 long alarm", d, 16'h2000);
    endtask

    task automatic t_addr();
        logic [15:0] d;
        wr(6'h07, 16'h1234); rd(6'h01, d); chk("R8 bad write addr alarm", d, 16'h1000);
        rd(6'h08, d); chk("R8 bad read returns zero", d, 16'h0000);
        rd(6'h01, d); chk("R8 bad read addr alarm", d, 16'h1000);
    endtask

    task automatic t_parity();
        logic [23:0] g;
        logic [15:0] d;
        wr(6'h00, 16'h8000);
        xfer(mk(1'b0, 6'h04, 16'h0033) ^ 24'h1, 24, g);
        chk("R9 bad parity not committed", linearize_o, 8'hA5);
        rd(6'h01, d); chk("R9 parity alarm", d, 16'h8000);
        wr(6'h04, 16'h0033); chk("R9 good parity commits", linearize_o, 8'h33);
        wr(6'h00, 16'h0000);
        xfer(mk(1'b0, 6'h04, 16'h0044) ^ 24'h1, 24, g);
        chk("R9 parity off commits", linearize_o, 8'h44);
        rd(6'h01, d); chk("R9 parity off no alarm", d, 16'h0000);
    endtask

    task automatic t_mask();
        logic [23:0] g;
        logic [15:0] d;
        wr(6'h02, 16'h4000);
        xfer(mk(1'b0, 6'h03, 16'h0000), 10, g);
        chk("R10 masked alarm stays low", alarm_o, 4'h0);
        xfer(mk(1'b0, 6'h03, 16'h0000), 25, g);
        rd(6'h01, d); chk("R10 unmasked alarm sets", d, 16'h2000);
    endtask

    task automatic t_softrst();
        logic [15:0] d;
        wr(6'h00, 16'h8000);
        wr(6'h00, 16'hC000);
        chk("R4 soft reset clears outputs", {parity_en_o, enable_o, linearize_o,
             lo_sideband_o, i_phase_o, q_phase_o, adc_ctrl_o, alarm_mask_o}, 32'h0);
        rd(6'h00, d); chk("R4 soft reset bit reads 0", d, 16'h00A1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_rw();
        t_ro();
        t_len();
        t_addr();
        t_parity();
        t_mask();
        t_softrst();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule